// File: doc/BRIEF.md
# Cache ECC Error Recovery Controller

This block sits beside the tag and data arrays of a cache and screens every lookup for storage errors. Each tag word and data word is kept with an extended Hamming check field (single-error correct, double-error detect). The block produces that field for words being written. On a read it decodes both words, corrects a single flipped bit and sorts the lookup into one of three outcomes: clean, recoverable or unrecoverable.

A clean lookup is passed straight on to the requester. A recoverable error starts a recovery sequence. When the line is a dirty data-cache line, the corrected tag and data are first offered to the write buffer. The affected index and way are then invalidated, and the requester is told to retry so that it refetches the value from memory. Data-cache lookups that cannot be corrected and would lose modified data, or that have a corrupted tag, raise an unrecoverable flag instead. The controller takes a new lookup only while it is idle.

The sequencer has four states. ST_IDLE accepts lookups. ST_WBACK holds the write-back request. ST_INVAL holds the invalidate command. ST_RETRY lasts one cycle. Transitions: ST_IDLE to ST_WBACK on a recoverable error in a dirty data line. ST_IDLE to ST_INVAL on any other recoverable error. ST_IDLE stays in ST_IDLE on a clean or unrecoverable lookup. ST_WBACK to ST_INVAL when wb_ready is high. ST_INVAL to ST_RETRY when inv_done is high. ST_RETRY always returns to ST_IDLE.

Top module: `cache_ecc_recovery`

## Requirements
- R1: The check field for a K-bit word has P+1 bits, where P is the smallest value with 2^P >= K+P+1. Data bit k (LSB first) takes the k-th codeword position from 1 upward that is not a power of two. Check bit j (j < P) is the XOR of the data bits whose position has bit j set. The top check bit is the XOR of all data bits and the P lower check bits. wr_tag_chk and wr_data_chk show this combinationally for 20-bit tags (6 check bits) and 32-bit data (7 check bits).
- R2: A lookup with no error in either word gives hit_valid high for exactly the next cycle, with out_tag and out_data equal to the stored words. No recovery follows.
- R3: A single-bit error in the data, the tag, or any of their check bits is corrected. From the cycle after the lookup, out_tag and out_data hold the original words.
- R4: Every recoverable error leads to inv_req high, with inv_index and inv_way equal to the lookup's index and way. inv_req stays high until a cycle in which inv_done is high. It starts in the cycle after the lookup, or in the cycle after the write-back handshake.
- R5: retry is high for exactly the one cycle after the cycle in which inv_req and inv_done are both high. It is never high otherwise.
- R6: A data-cache lookup (lk_icache low) on a dirty line with only single-bit errors raises wb_req from the next cycle, with the corrected out_tag/out_data as payload. wb_req is held until wb_ready is high, and the invalidate follows in the next cycle.
- R7: A data-cache lookup with a double-bit tag error, or with a double-bit data error on a dirty line, pulses unrec_err for the next cycle. No write-back, invalidate or retry follows.
- R8: An instruction-cache lookup (lk_icache high) with any error, single or double, in tag or data, is invalidated and retried. lk_dirty is ignored, and there is never a write-back or an unrecoverable flag.
- R9: A double-bit data error on a clean data-cache line with a good tag is invalidated and retried without a write-back.
- R10: lk_valid is ignored while busy is high. Such a lookup changes no output: no hit_valid and no change of out_tag, out_data, inv_index or inv_way.
- R11: While rst_n is low, busy, hit_valid, wb_req, inv_req, retry and unrec_err are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_tag | input | 20 | Tag being written to the array |
| wr_data | input | 32 | Data word being written to the array |
| wr_tag_chk | output | 6 | Check field for wr_tag |
| wr_data_chk | output | 7 | Check field for wr_data |
| lk_valid | input | 1 | Lookup word pair present this cycle |
| lk_icache | input | 1 | Lookup belongs to the instruction cache |
| lk_dirty | input | 1 | Looked-up line holds modified data |
| lk_index | input | 7 | Set index of the lookup |
| lk_way | input | 2 | Way of the lookup |
| rd_tag | input | 20 | Tag read from the array |
| rd_tag_chk | input | 6 | Stored check field of the tag |
| rd_data | input | 32 | Data read from the array |
| rd_data_chk | input | 7 | Stored check field of the data |
| wb_ready | input | 1 | Write buffer takes the write-back this cycle |
| inv_done | input | 1 | Array has finished the clean/invalidate |
| busy | output | 1 | Recovery in progress; lookups ignored |
| hit_valid | output | 1 | One-cycle pulse for an error-free lookup |
| out_tag | output | 20 | Corrected tag of the last accepted lookup |
| out_data | output | 32 | Corrected data of the last accepted lookup; write-back payload |
| wb_req | output | 1 | Write-back request to the write buffer |
| inv_req | output | 1 | Clean/invalidate command |
| inv_index | output | 7 | Index to invalidate |
| inv_way | output | 2 | Way to invalidate |
| retry | output | 1 | One-cycle retry indication to the requester |
| unrec_err | output | 1 | One-cycle unrecoverable-error flag |

## Verification
hit_valid, unrec_err, out_tag and out_data are due one clock edge after the lookup is presented. wb_req or inv_req rises at that same edge. The next request follows one edge after the accepting wb_ready or inv_done, and retry follows one edge after inv_done. The check field is combinational and is compared in the same cycle. The bench runs a behavioural model that advances on the same rising edge from the inputs the bench itself drove. It compares every output against the model at the following falling edge, so each result is sampled in the cycle it is due. Handshake latencies are varied so that the hold behaviour of the requests is exercised.

// File: rtl/cache_ecc_pkg.sv
package cache_ecc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WBACK,
        ST_INVAL,
        ST_RETRY
    } rec_state_e;

    // number of Hamming parity bits (without the overall parity bit)
    function automatic int npar(input int dw);
        int p;
        p = 1;
        while ((1 << p) < dw + p + 1) p++;
        return p;
    endfunction

    // codeword position (1-based) of data bit k, skipping powers of two
    function automatic int hpos(input int k);
        int pos;
        pos = k + 1;
        for (int j = 0; j < 16; j++) begin
            if ((1 << j) <= pos) pos++;
        end
        return pos;
    endfunction

endpackage

// File: rtl/secded_gen.sv
module secded_gen
    import cache_ecc_pkg::*;
#(
    parameter int DW = 32,
    localparam int P  = npar(DW),
    localparam int CW = P + 1
) (
    input  logic [DW-1:0] din,
    output logic [CW-1:0] chk
);

    logic [P-1:0] par;

    always_comb begin
        par = '0;
        for (int k = 0; k < DW; k++) begin
            for (int j = 0; j < P; j++) begin
                if (((hpos(k) >> j) & 1) == 1) par[j] = par[j] ^ din[k];
            end
        end
    end

    assign chk = {(^din) ^ (^par), par};

endmodule

// File: rtl/secded_chk.sv
module secded_chk
    import cache_ecc_pkg::*;
#(
    parameter int DW = 32,
    localparam int P  = npar(DW),
    localparam int CW = P + 1,
    localparam int N  = DW + P
) (
    input  logic [DW-1:0] din,
    input  logic [CW-1:0] chk,
    output logic [DW-1:0] dout,
    output logic          sgl,
    output logic          dbl
);

    logic [P-1:0] syn;
    logic         ovr;
    logic         in_range;

    always_comb begin
        syn = chk[P-1:0];
        for (int k = 0; k < DW; k++) begin
            for (int j = 0; j < P; j++) begin
                if (((hpos(k) >> j) & 1) == 1) syn[j] = syn[j] ^ din[k];
            end
        end
    end

    assign ovr      = ^{din, chk};
    assign in_range = (int'(syn) <= N);

    always_comb begin
        dout = din;
        for (int k = 0; k < DW; k++) begin
            if (ovr && syn == P'(hpos(k))) dout[k] = ~din[k];
        end
    end

    assign sgl = ovr && in_range;
    assign dbl = (!ovr && syn != '0) || (ovr && !in_range);

    // R3
    always_comb begin
        sgl_dbl_excl_chk: assert (!(sgl && dbl));
    end

endmodule

// File: rtl/cache_ecc_fsm.sv
module cache_ecc_fsm
    import cache_ecc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lk_valid,
    input  logic lk_icache,
    input  logic lk_dirty,
    input  logic tag_sgl,
    input  logic tag_dbl,
    input  logic data_sgl,
    input  logic data_dbl,
    input  logic wb_ready,
    input  logic inv_done,
    output logic accept,
    output logic busy,
    output logic wb_req,
    output logic inv_req,
    output logic retry,
    output logic hit_valid,
    output logic unrec_err
);

    rec_state_e state, nxt;
    logic any_err, fatal;

    assign any_err = tag_sgl | tag_dbl | data_sgl | data_dbl;
    assign fatal   = !lk_icache && (tag_dbl || (data_dbl && lk_dirty));
    assign accept  = (state == ST_IDLE) && lk_valid;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (accept && any_err && !fatal)
                    nxt = (!lk_icache && lk_dirty) ? ST_WBACK : ST_INVAL;
            end
            ST_WBACK: if (wb_ready) nxt = ST_INVAL;
            ST_INVAL: if (inv_done) nxt = ST_RETRY;
            ST_RETRY: nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        busy    = 1'b0;
        wb_req  = 1'b0;
        inv_req = 1'b0;
        retry   = 1'b0;
        unique case (state)
            ST_IDLE:  ;
            ST_WBACK: begin busy = 1'b1; wb_req  = 1'b1; end
            ST_INVAL: begin busy = 1'b1; inv_req = 1'b1; end
            ST_RETRY: begin busy = 1'b1; retry   = 1'b1; end
            default:  ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hit_valid <= 1'b0;
            unrec_err <= 1'b0;
        end else begin
            hit_valid <= accept && !any_err;
            unrec_err <= accept && fatal;
        end
    end

    // R5
    retry_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        retry |=> !retry);
    // R5
    retry_after_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        retry |-> $past(inv_req && inv_done));
    // R4
    inv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_req && !inv_done) |=> inv_req);
    // R6
    wb_then_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_req && wb_ready) |=> inv_req);
    // R7
    unrec_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unrec_err |-> !busy);
    // R8
    icache_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && lk_icache) |=> (!wb_req && !unrec_err));

endmodule

// File: rtl/cache_ecc_recovery.sv
module cache_ecc_recovery
    import cache_ecc_pkg::*;
#(
    parameter int TAG_W  = 20,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 7,
    parameter int WAY_W  = 2,
    localparam int TCW   = npar(TAG_W) + 1,
    localparam int DCW   = npar(DATA_W) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data,
    output logic [TCW-1:0]    wr_tag_chk,
    output logic [DCW-1:0]    wr_data_chk,
    input  logic              lk_valid,
    input  logic              lk_icache,
    input  logic              lk_dirty,
    input  logic [IDX_W-1:0]  lk_index,
    input  logic [WAY_W-1:0]  lk_way,
    input  logic [TAG_W-1:0]  rd_tag,
    input  logic [TCW-1:0]    rd_tag_chk,
    input  logic [DATA_W-1:0] rd_data,
    input  logic [DCW-1:0]    rd_data_chk,
    input  logic              wb_ready,
    input  logic              inv_done,
    output logic              busy,
    output logic              hit_valid,
    output logic [TAG_W-1:0]  out_tag,
    output logic [DATA_W-1:0] out_data,
    output logic              wb_req,
    output logic              inv_req,
    output logic [IDX_W-1:0]  inv_index,
    output logic [WAY_W-1:0]  inv_way,
    output logic              retry,
    output logic              unrec_err
);

    logic [TAG_W-1:0]  tag_fix;
    logic [DATA_W-1:0] data_fix;
    logic tag_sgl, tag_dbl, data_sgl, data_dbl, accept;

    secded_gen #(.DW(TAG_W))  u_gen_tag  (.din(wr_tag),  .chk(wr_tag_chk));
    secded_gen #(.DW(DATA_W)) u_gen_data (.din(wr_data), .chk(wr_data_chk));

    secded_chk #(.DW(TAG_W)) u_chk_tag (
        .din(rd_tag), .chk(rd_tag_chk), .dout(tag_fix),
        .sgl(tag_sgl), .dbl(tag_dbl));
    secded_chk #(.DW(DATA_W)) u_chk_data (
        .din(rd_data), .chk(rd_data_chk), .dout(data_fix),
        .sgl(data_sgl), .dbl(data_dbl));

    cache_ecc_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid),
        .lk_icache(lk_icache), .lk_dirty(lk_dirty),
        .tag_sgl(tag_sgl), .tag_dbl(tag_dbl),
        .data_sgl(data_sgl), .data_dbl(data_dbl),
        .wb_ready(wb_ready), .inv_done(inv_done),
        .accept(accept), .busy(busy), .wb_req(wb_req),
        .inv_req(inv_req), .retry(retry),
        .hit_valid(hit_valid), .unrec_err(unrec_err));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_tag   <= '0;
            out_data  <= '0;
            inv_index <= '0;
            inv_way   <= '0;
        end else if (accept) begin
            out_tag   <= tag_fix;
            out_data  <= data_fix;
            inv_index <= lk_index;
            inv_way   <= lk_way;
        end
    end

    // R10
    payload_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(inv_index) && $stable(out_data)));
    // R2
    hit_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_valid |-> !busy);

endmodule

// File: tb/cache_ecc_recovery_test.sv
`timescale 1ns/1ps
module cache_ecc_recovery_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [19:0] wr_tag = '0;
    logic [31:0] wr_data = '0;
    logic [5:0]  wr_tag_chk;
    logic [6:0]  wr_data_chk;
    logic lk_valid = 0, lk_icache = 0, lk_dirty = 0;
    logic [6:0]  lk_index = '0;
    logic [1:0]  lk_way = '0;
    logic [19:0] rd_tag = '0;
    logic [5:0]  rd_tag_chk = '0;
    logic [31:0] rd_data = '0;
    logic [6:0]  rd_data_chk = '0;
    logic wb_ready = 0, inv_done = 0;
    logic busy, hit_valid, wb_req, inv_req, retry, unrec_err;
    logic [19:0] out_tag;
    logic [31:0] out_data;
    logic [6:0]  inv_index;
    logic [1:0]  inv_way;

    cache_ecc_recovery uut (.*);

    int n_tests = 0, n_fail = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // independent extended Hamming encoder
    function automatic logic [7:0] encode(input logic [63:0] d, input int dw);
        logic [7:0] c;
        int p, k, pos;
        c = '0;
        p = 1;
        while ((1 << p) < dw + p + 1) p++;
        k = 0;
        pos = 1;
        while (k < dw) begin
            if ((pos & (pos - 1)) != 0) begin
                for (int j = 0; j < p; j++)
                    if (pos[j]) c[j] = c[j] ^ d[k];
                k++;
            end
            pos++;
        end
        c[p] = (^d) ^ (^c);
        return c;
    endfunction

    // stimulus knowledge used by the model
    logic [19:0] g_tag;
    logic [31:0] g_data;
    int g_tfl, g_dfl;
    int wb_lat = 0, inv_lat = 0;

    // reference model
    typedef enum int {M_IDLE, M_WB, M_INV, M_RTY} mst_t;
    mst_t m_st = M_IDLE;
    bit m_hit = 0, m_unrec = 0, m_pay_ok = 0;
    logic [19:0] m_tag = '0;
    logic [31:0] m_data = '0;
    logic [6:0] m_idx = '0;
    logic [1:0] m_way = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = M_IDLE; m_hit = 0; m_unrec = 0; m_pay_ok = 1;
            m_tag = '0; m_data = '0; m_idx = '0; m_way = '0;
        end else begin
            m_hit = 0;
            m_unrec = 0;
            case (m_st)
                M_IDLE: if (lk_valid) begin
                    bit err, fat;
                    err = (g_tfl > 0) || (g_dfl > 0);
                    fat = !lk_icache && (g_tfl >= 2 || (g_dfl >= 2 && lk_dirty));
                    m_hit = !err;
                    m_unrec = fat;
                    m_pay_ok = (g_tfl < 2) && (g_dfl < 2);
                    m_tag = g_tag; m_data = g_data;
                    m_idx = lk_index; m_way = lk_way;
                    if (err && !fat) m_st = (!lk_icache && lk_dirty) ? M_WB : M_INV;
                end
                M_WB:  if (wb_ready) m_st = M_INV;
                M_INV: if (inv_done) m_st = M_RTY;
                M_RTY: m_st = M_IDLE;
                default: m_st = M_IDLE;
            endcase
        end
    end

    // write buffer / array responders
    int wcnt = 0, icnt = 0;
    always @(negedge clk) begin
        wb_ready = wb_req && (wcnt >= wb_lat);
        wcnt = wb_req ? wcnt + 1 : 0;
        inv_done = inv_req && (icnt >= inv_lat);
        icnt = inv_req ? icnt + 1 : 0;
    end

    // per-cycle comparison
    always @(negedge clk) begin
        if (!rst_n) begin
            check({busy, hit_valid, wb_req, inv_req, retry, unrec_err} == 6'b0,
                  "R11", "reset outputs", {58'b0, busy, hit_valid, wb_req, inv_req, retry, unrec_err}, 0);
        end else begin
            check(busy == (m_st != M_IDLE), "R10", "busy", 64'(busy), 64'(m_st != M_IDLE));
            check(hit_valid == m_hit, "R2", "hit_valid", 64'(hit_valid), 64'(m_hit));
            check(unrec_err == m_unrec, "R7", "unrec_err", 64'(unrec_err), 64'(m_unrec));
            check(wb_req == (m_st == M_WB), "R6", "wb_req", 64'(wb_req), 64'(m_st == M_WB));
            check(inv_req == (m_st == M_INV), "R4", "inv_req", 64'(inv_req), 64'(m_st == M_INV));
            check(retry == (m_st == M_RTY), "R5", "retry", 64'(retry), 64'(m_st == M_RTY));
            if (m_pay_ok) begin
                check(out_data == m_data, "R3", "out_data", 64'(out_data), 64'(m_data));
                check(out_tag == m_tag, "R3", "out_tag", 64'(out_tag), 64'(m_tag));
            end
            if (m_st == M_INV)
                check({inv_index, inv_way} == {m_idx, m_way}, "R4", "inv target",
                      64'({inv_index, inv_way}), 64'({m_idx, m_way}));
            check(wr_tag_chk == encode(64'(wr_tag), 20)[5:0], "R1", "wr_tag_chk",
                  64'(wr_tag_chk), 64'(encode(64'(wr_tag), 20)));
            check(wr_data_chk == encode(64'(wr_data), 32)[6:0], "R1", "wr_data_chk",
                  64'(wr_data_chk), 64'(encode(64'(wr_data), 32)));
        end
    end

    // one lookup; tm/dm flip masks over {check, word}
    task automatic lookup(input logic [19:0] t, input logic [31:0] d,
                          input logic [25:0] tm, input logic [38:0] dm,
                          input bit ic, input bit dirty,
                          input logic [6:0] idx, input logic [1:0] way);
        logic [25:0] tcw;
        logic [38:0] dcw;
        @(negedge clk);
        wr_tag = t;
        wr_data = d;
        tcw = {encode(64'(t), 20)[5:0], t} ^ tm;
        dcw = {encode(64'(d), 32)[6:0], d} ^ dm;
        if (!busy) begin
            g_tag = t; g_data = d;
            g_tfl = $countones(tm); g_dfl = $countones(dm);
        end
        rd_tag = tcw[19:0]; rd_tag_chk = tcw[25:20];
        rd_data = dcw[31:0]; rd_data_chk = dcw[38:32];
        lk_icache = ic; lk_dirty = dirty; lk_index = idx; lk_way = way;
        lk_valid = 1'b1;
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    task automatic settle();
        int n = 0;
        while ((busy || m_st != M_IDLE) && n < 100) begin
            @(negedge clk);
            n++;
        end
        @(negedge clk);
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        g_tag = '0; g_data = '0; g_tfl = 0; g_dfl = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R2 clean lookups
        lookup(20'hABCDE, 32'hDEADBEEF, '0, '0, 0, 0, 7'd5, 2'd1); settle();
        lookup(20'h00001, 32'h00000000, '0, '0, 1, 1, 7'd0, 2'd0); settle();
        // R3 R4 R5 single data error, clean dcache line
        lookup(20'h12345, 32'hCAFEF00D, '0, 39'h1 << 17, 0, 0, 7'd33, 2'd2); settle();
        // R3 R8 single tag error, icache
        lookup(20'h54321, 32'h01234567, 26'h1 << 3, '0, 1, 0, 7'd9, 2'd3); settle();
        // R6 dirty dcache single data error, write buffer slow
        wb_lat = 2; inv_lat = 1;
        lookup(20'h0F0F0, 32'h89ABCDEF, '0, 39'h1 << 31, 0, 1, 7'd100, 2'd1); settle();
        // R6 dirty dcache single tag error, immediate accept
        wb_lat = 0; inv_lat = 0;
        lookup(20'hFFFFF, 32'h13579BDF, 26'h1 << 19, '0, 0, 1, 7'd127, 2'd3); settle();
        // R3 check-bit-only errors
        lookup(20'h2468A, 32'h2468ACE0, 26'h1 << 25, 39'h1 << 32, 0, 0, 7'd64, 2'd0); settle();
        // R7 double data error on dirty dcache line
        lookup(20'h11111, 32'h22222222, '0, 39'h5, 0, 1, 7'd12, 2'd1); settle();
        // R7 double tag error on clean dcache line
        lookup(20'h33333, 32'h44444444, 26'h3 << 10, '0, 0, 0, 7'd13, 2'd2); settle();
        // R9 double data error on clean dcache line
        lookup(20'h55555, 32'h66666666, '0, 39'h1 | (39'h1 << 38), 0, 0, 7'd14, 2'd3); settle();
        // R8 icache double data error with dirty input set
        lookup(20'h77777, 32'h88888888, '0, 39'h3 << 20, 1, 1, 7'd15, 2'd0); settle();
        // R8 icache double tag error
        lookup(20'h99999, 32'hAAAAAAAA, 26'h9, '0, 1, 0, 7'd16, 2'd1); settle();
        // R10 lookups while busy are ignored
        inv_lat = 4;
        lookup(20'hBBBBB, 32'hCCCCCCCC, '0, 39'h1 << 5, 0, 0, 7'd20, 2'd2);
        lookup(20'hDDDDD, 32'hEEEEEEEE, '0, '0, 0, 0, 7'd21, 2'd3);
        lookup(20'h0000F, 32'h0000FFFF, '0, 39'h1 << 7, 1, 0, 7'd22, 2'd0);
        settle();
        inv_lat = 0;
        // R1 R2 varied clean patterns
        for (int i = 0; i < 16; i++) begin
            lookup(20'(i * 32'h1357), 32'(i) * 32'h9E3779B9, '0, '0, i[0], i[1],
                   7'(i * 5), 2'(i));
        end
        // R3 single errors at every data position
        for (int i = 0; i < 39; i++) begin
            lookup(20'(i * 77), 32'h5A5A0000 + 32'(i), '0, 39'h1 << i, 0, 0, 7'(i), 2'(i));
            settle();
        end
        settle();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule